// File: doc/BRIEF.md
# Byte/Word ROM Read Port with Identification Readout

This block is a clocked model of the read side of a 16-bit mask ROM whose data bus can be narrowed to 8 bits. The read is enabled by an active-low chip select and an active-low read enable. When either one is inactive the port drives nothing. In wide mode the full addressed word is presented. In narrow mode only the low lane is driven, and an extra least-significant address input picks which half of the word appears on that lane. The upper lane is released.

A separate identify strobe replaces the array with two fixed code words. These are a maker code and a device code, selected by address bit 0. They are valid only when every other address bit is zero. Any other address in identify mode returns zero data and raises an error flag. The array is a small constant memory computed at elaboration. The first `PROG_WORDS` locations hold a fixed pattern, and the rest read as erased (all ones). Every output is registered, so inputs presented before a rising edge are reflected just after that edge.

Top module: `rom_rd_port`

## Requirements
- R1: While reset (`rstN` low) is held, and right after it, `dataOut` is 0, `laneOe` is 2'b00 and `idErr` is 0.
- R2: With `selN`=0, `readN`=0, `byteMode`=0 and `idStrobe`=0, after the next rising edge `dataOut` equals the word at `addr` and `laneOe` is 2'b11.
- R3: With both enables active and `byteMode`=1, the following things hold after the next edge. `laneOe` is 2'b01 and `dataOut[15:8]` is 0. `dataOut[7:0]` holds bits 15:8 of the selected word when `lowAddr`=1, and bits 7:0 when `lowAddr`=0.
- R4: With `selN`=1, after the next edge `laneOe` is 2'b00, `dataOut` is 0 and `idErr` is 0, whatever `readN` is.
- R5: With `selN`=0 and `readN`=1, after the next edge `laneOe` is 2'b00, `dataOut` is 0 and `idErr` is 0.
- R6: With both enables active, `idStrobe`=1 and `addr[ADDR_W-1:1]`=0, the selected word is 16'h00C2 when `addr[0]`=0 and 16'hB800 when `addr[0]`=1. The lane rules of R2 and R3 apply to it.
- R7: With both enables active, `idStrobe`=1 and any bit of `addr[ADDR_W-1:1]` set, after the next edge `idErr` is 1 and `dataOut` is 0. `laneOe` still follows the mode.
- R8: The array word at location k (k < `PROG_WORDS`) is {k[7:0] XOR 8'hA5, (k[7:0] + 8'h3C) mod 256}. Every location at or above `PROG_WORDS` reads 16'hFFFF.
- R9: `idErr` is 1 only in the cycle after an identify access with a nonzero upper address. It is 0 after every other access.
- R10: In wide mode `lowAddr` has no effect on `dataOut` or `laneOe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| selN | input | 1 | Active-low chip select |
| readN | input | 1 | Active-low read (output) enable |
| byteMode | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| lowAddr | input | 1 | Half-word select in byte mode (1 = upper half) |
| idStrobe | input | 1 | Identify mode: return code words instead of the array |
| addr | input | ADDR_W | Word address |
| dataOut | output | 16 | Registered read data |
| laneOe | output | 2 | Per-byte-lane drive enable, bit 0 low lane, bit 1 high lane |
| idErr | output | 1 | Identify access with a nonzero upper address |

## Verification
The hardest cases to reach are combinations of modes: identify mode used together with byte-lane steering, and the error path entered in byte mode. With random addresses these rarely line up with the rule that the upper address must be zero. The stimulus therefore uses directed sweeps that cross both code addresses with both lane selects and both bus widths. A pseudo-random phase is biased so that most identify accesses use addresses 0 and 1, plus a few nonzero upper addresses. The erased-region boundary at `PROG_WORDS` is hit directly, one location on each side of it.

// File: rtl/rom_rd_port_pkg.sv
package rom_rd_port_pkg;

  localparam logic [15:0] MAKER_CODE  = 16'h00C2;
  localparam logic [15:0] DEVICE_CODE = 16'hB800;
  localparam logic [15:0] ERASED_WORD = 16'hFFFF;

  typedef struct packed {
    logic drive;     // both enables active
    logic byteLane;  // narrow bus
    logic pickHigh;  // upper half onto low lane
    logic useId;     // identify readout
    logic idBad;     // identify with nonzero upper address
  } portStrobeT;

  function automatic logic [15:0] initWord(input int unsigned k, input int unsigned progWords);
    logic [7:0] lo8;
    lo8 = 8'(k);
    if (k < progWords) return {lo8 ^ 8'hA5, lo8 + 8'h3C};
    return ERASED_WORD;
  endfunction

endpackage

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
  import rom_rd_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              selN,
  input  logic              readN,
  input  logic              byteMode,
  input  logic              lowAddr,
  input  logic              idStrobe,
  input  logic [ADDR_W-1:0] addr,
  output portStrobeT        strobe
);

  logic upperNonZero;

  always_comb begin
    upperNonZero    = |addr[ADDR_W-1:1];
    strobe.drive    = !selN && !readN;
    strobe.byteLane = byteMode;
    strobe.pickHigh = byteMode && lowAddr;
    strobe.useId    = idStrobe;
    strobe.idBad    = idStrobe && upperNonZero;
  end

endmodule

// File: rtl/rom_rd_data.sv
module rom_rd_data
  import rom_rd_port_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PROG_WORDS = 192
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobeT        strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [15:0]       dataOut,
  output logic [1:0]        laneOe,
  output logic              idErr
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0] romWord [DEPTH];
  logic [15:0] pickedWord;
  logic [15:0] nextData;
  logic [1:0]  nextOe;
  logic        nextErr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign romWord[i] = initWord(i, PROG_WORDS);
  end

  always_comb begin
    if (!strobe.useId)     pickedWord = romWord[addr];
    else if (strobe.idBad) pickedWord = '0;
    else if (addr[0])      pickedWord = DEVICE_CODE;
    else                   pickedWord = MAKER_CODE;

    nextData = '0;
    nextOe   = 2'b00;
    nextErr  = 1'b0;
    if (strobe.drive) begin
      nextErr = strobe.idBad;
      if (strobe.byteLane) begin
        nextOe   = 2'b01;
        nextData = {8'h00, strobe.pickHigh ? pickedWord[15:8] : pickedWord[7:0]};
      end else begin
        nextOe   = 2'b11;
        nextData = pickedWord;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      laneOe  <= 2'b00;
      idErr   <= 1'b0;
    end else begin
      dataOut <= nextData;
      laneOe  <= nextOe;
      idErr   <= nextErr;
    end
  end

  AST_UPPER_LANE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (laneOe == 2'b01) |-> (dataOut[15:8] == 8'h00)); // R3

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    idErr |-> (dataOut == 16'h0000)); // R7

endmodule

// File: rtl/rom_rd_port.sv
module rom_rd_port
  import rom_rd_port_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PROG_WORDS = 192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              readN,
  input  logic              byteMode,
  input  logic              lowAddr,
  input  logic              idStrobe,
  input  logic [ADDR_W-1:0] addr,
  output logic [15:0]       dataOut,
  output logic [1:0]        laneOe,
  output logic              idErr
);

  portStrobeT strobe;

  rom_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .selN(selN), .readN(readN), .byteMode(byteMode), .lowAddr(lowAddr),
    .idStrobe(idStrobe), .addr(addr), .strobe(strobe)
  );

  rom_rd_data #(.ADDR_W(ADDR_W), .PROG_WORDS(PROG_WORDS)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .dataOut(dataOut), .laneOe(laneOe), .idErr(idErr)
  );

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    $past(selN) |-> (laneOe == 2'b00 && dataOut == 16'h0000 && !idErr)); // R4

  AST_OUTPUT_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!selN) && $past(readN)) |-> (laneOe == 2'b00 && !idErr)); // R5

  AST_WIDE_BOTH_LANES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!selN && !readN && !byteMode)) |-> (laneOe == 2'b11)); // R2

  AST_NARROW_LOW_LANE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!selN && !readN && byteMode)) |-> (laneOe == 2'b01)); // R3

  AST_ERR_ONLY_ID: assert property (@(posedge clk) disable iff (!rstN)
    idErr |-> $past(idStrobe && !selN && !readN)); // R9

endmodule

// File: tb/rom_rd_port_test.sv
`timescale 1ns/1ps
module rom_rd_port_test;

  localparam int AW   = 8;
  localparam int PROG = 192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, readN = 1'b1, byteMode = 1'b0, lowAddr = 1'b0, idStrobe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dataOut;
  logic [1:0]  laneOe;
  logic        idErr;

  int vectors = 0;
  int misses  = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  rom_rd_port #(.ADDR_W(AW), .PROG_WORDS(PROG)) uut (
    .clk(clk), .rstN(rstN), .selN(selN), .readN(readN), .byteMode(byteMode),
    .lowAddr(lowAddr), .idStrobe(idStrobe), .addr(addr),
    .dataOut(dataOut), .laneOe(laneOe), .idErr(idErr)
  );

  // reference: returns {err, oe[1:0], data[15:0]}
  function automatic logic [18:0] refModel(input logic s, input logic r, input logic b,
                                           input logic l, input logic id, input int a);
    int w;
    logic e;
    if (s || r) return 19'd0;
    e = 1'b0;
    if (id) begin
      if (a / 2 != 0) begin w = 0; e = 1'b1; end
      else w = (a % 2 == 1) ? 'hB800 : 'h00C2;
    end else if (a < PROG) begin
      w = (((a % 256) ^ 'hA5) * 256) + ((a + 60) % 256);
    end else begin
      w = 'hFFFF;
    end
    if (b) return {e, 2'b01, 8'h00, l ? 8'(w / 256) : 8'(w % 256)};
    return {e, 2'b11, 16'(w)};
  endfunction

  task automatic compare(input logic [18:0] exp, input string tag);
    vectors++;
    if ({idErr, laneOe, dataOut} !== exp) begin
      misses++;
      $display("FAIL %s: got err=%b oe=%b data=%h, expected err=%b oe=%b data=%h",
               tag, idErr, laneOe, dataOut, exp[18], exp[17:16], exp[15:0]);
    end
  endtask

  function automatic string tagOf(input logic s, input logic r, input logic b,
                                  input logic id, input int a);
    if (s) return "R4";
    if (r) return "R5";
    if (id) return (a / 2 != 0) ? "R7" : "R6";
    if (b) return "R3";
    return (a >= PROG - 1) ? "R8" : "R2";
  endfunction

  // drive at a falling edge, sample at the next falling edge
  task automatic vec(input logic s, input logic r, input logic b, input logic l,
                     input logic id, input int a, input string tag);
    selN = s; readN = r; byteMode = b; lowAddr = l; idStrobe = id; addr = AW'(a);
    @(negedge clk);
    compare(refModel(s, r, b, l, id, a), tag);
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    #2_000_000;
    misses++;
    $display("FAIL watchdog: got no finish, expected finish before timeout");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    @(negedge clk);
    selN = 1'b0; readN = 1'b0; addr = 8'd3;
    @(negedge clk);
    compare(19'd0, "R1");               // held in reset with enables active
    @(negedge clk);
    compare(19'd0, "R1");
    selN = 1'b1; readN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compare(19'd0, "R1");               // first cycle after release, deselected

    // R2 / R8: wide reads, including both sides of the erased boundary
    vec(0, 0, 0, 0, 0, 0, "R2");
    vec(0, 0, 0, 0, 0, 7, "R2");
    vec(0, 0, 0, 0, 0, PROG - 1, "R8");
    vec(0, 0, 0, 0, 0, PROG, "R8");
    vec(0, 0, 0, 0, 0, 255, "R8");
    // R10: lowAddr toggled in wide mode
    vec(0, 0, 0, 1, 0, 7, "R10");
    vec(0, 0, 0, 1, 0, PROG, "R10");
    // R3: byte lane steering
    vec(0, 0, 1, 0, 0, 7, "R3");
    vec(0, 0, 1, 1, 0, 7, "R3");
    vec(0, 0, 1, 1, 0, PROG + 3, "R3");
    // R4 / R5: disables with otherwise active inputs
    vec(1, 0, 0, 0, 0, 7, "R4");
    vec(1, 1, 1, 1, 1, 5, "R4");
    vec(0, 1, 0, 0, 0, 7, "R5");
    vec(0, 1, 0, 0, 1, 6, "R5");
    // R6: identify codes in both widths
    for (int a = 0; a < 2; a++) begin
      vec(0, 0, 0, 0, 1, a, "R6");
      vec(0, 0, 1, 0, 1, a, "R6");
      vec(0, 0, 1, 1, 1, a, "R6");
    end
    // R7 / R9: bad identify address, then error clears
    vec(0, 0, 0, 0, 1, 2, "R7");
    vec(0, 0, 1, 1, 1, 129, "R7");
    vec(0, 0, 0, 0, 0, 2, "R9");
    vec(0, 0, 0, 0, 1, 3, "R7");
    vec(1, 0, 0, 0, 1, 3, "R9");

    // biased pseudo-random phase
    for (int n = 0; n < 600; n++) begin
      logic s, r, b, l, id;
      int a;
      seed = nextRand(seed);
      s  = (seed[2:0] == 3'd0);
      r  = (seed[5:3] == 3'd0);
      b  = seed[6];
      l  = seed[7];
      id = (seed[10:8] == 3'd0);
      a  = (id && seed[11]) ? int'(seed[12]) : int'(seed[19:12]);
      vec(s, r, b, l, id, a, tagOf(s, r, b, id, a));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule